// File: doc/BRIEF.md
# Dual-Input Serial Audio Link Frame Receiver

This block deserializes the inbound half of a time-division serial audio link. Two serial data lines share one bit clock and one frame marker (SYNC). A frame starts with a 16-bit tag phase and continues with twelve 20-bit data slots. The first tag bit reports whether the attached codec is ready. The next twelve tag bits report which slots carry valid data. Both data lines go through the same framing engine and are decoded in exactly the same way. Their results are kept apart, so that any status, such as a wake event, can be traced to the line that raised it.

All sampling happens on the falling edge of the bit clock, and the driving side changes data on the rising edge. For each line, every slot is assembled most significant bit first. A one-bit-clock strobe marks a completed slot, and a shared slot index comes with it. While the link is shut off, decoding stops. If a line goes high during that time, a sticky wake flag is raised for that line.

Top module: `acl_rx_dual`

## Requirements
- R1: sync_i and sdin_i are sampled only on the falling edge of clk_i. Inputs that change on the rising edge are captured without error.
- R2: When sync_i is sampled high after being sampled low, that sample is tag bit 0 of a new frame. This holds even in the middle of a frame, and the frame in progress is abandoned.
- R3: For each line, ready_o is tag bit 0, and slot_valid_o[line*12 + k-1] is tag bit k, for k = 1..12. Tag bits 13..15 are ignored. These outputs update on the falling edge that samples tag bit 15, and they hold until the next such edge.
- R4: Slot k (k = 1..12) takes frame bit positions 16+20*(k-1) to 35+20*(k-1), most significant bit first. The falling edge that samples the last bit does three things: it loads slot_data_o[line*20 +: 20], it raises slot_stb_o[line] for exactly one bit clock, and it sets slot_idx_o to k.
- R5: Both lines are decoded identically and independently. A pattern on one line has no effect on the outputs of the other line.
- R6: A line held constant low decodes as not ready, with all twelve slots invalid and all slot data zero.
- R7: While shutoff_i is high, the block does not decode frames, raises no strobes, and clears ready_o and slot_valid_o. Also while shutoff_i is high, wake_o[line] is set when that line is sampled high, and it stays set until a falling edge samples shutoff_i low, which clears it.
- R8: After the last bit of slot 12, no strobe fires until a new SYNC rise.
- R9: While rst_ni is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock; sampling on its falling edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Frame marker, high during the tag phase |
| shutoff_i | input | 1 | Link shut off; decoding halted, wake detection armed |
| sdin_i | input | 2 | Serial data lines, one bit per line |
| ready_o | output | 2 | Codec-ready flag per line |
| slot_valid_o | output | 24 | Slot valid flags, 12 per line, slot k at bit line*12+k-1 |
| slot_data_o | output | 40 | Last completed slot word, 20 bits per line |
| slot_stb_o | output | 2 | One-cycle strobe per line on slot completion |
| slot_idx_o | output | 4 | Index 1..12 of the slot just completed |
| wake_o | output | 2 | Sticky wake flag per line |

## Verification
The bench builds the block with its default parameters: two lines, a 16-bit tag phase and twelve 20-bit slots. With these values a full 256-bit frame runs in a few hundred clocks. The bench can therefore drive several complete frames, an abandoned frame that is followed by an immediate resync, a line tied low, and a shut-off interval with wake on one line and then on both. Every slot word, index and tag decode on both lines is checked against a scoreboard.

// File: rtl/acl_rx_pkg.sv
package acl_rx_pkg;
  localparam int unsigned NUM_IN_DEF = 2;
  localparam int unsigned SLOTS_DEF  = 12;
  localparam int unsigned SLOT_W_DEF = 20;
  localparam int unsigned TAG_W_DEF  = 16;

  function automatic int unsigned cnt_width(int unsigned tag_w, int unsigned slot_w);
    int unsigned m;
    m = (tag_w > slot_w) ? tag_w : slot_w;
    return $clog2(m);
  endfunction
endpackage

// File: rtl/acl_rx_framer.sv
module acl_rx_framer #(
  parameter int unsigned TAG_W  = 16,
  parameter int unsigned SLOTS  = 12,
  parameter int unsigned SLOT_W = 20,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned CNT_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic             halt_i,
  output logic             bit_en_o,
  output logic [IDX_W-1:0] slot_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [IDX_W-1:0] idx_o
);
  logic             sync_q, active_q;
  logic [IDX_W-1:0] slot_q, idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise, last_tag, last_bit;

  always_comb begin
    rise     = sync_i & ~sync_q;
    bit_en_o = ~halt_i & (rise | active_q);
    slot_o   = rise ? '0 : slot_q;
    cnt_o    = rise ? '0 : cnt_q;
    last_tag = (slot_o == '0) && (cnt_o == CNT_W'(TAG_W - 1));
    last_bit = (slot_o != '0) && (cnt_o == '0);
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q   <= 1'b0;
      active_q <= 1'b0;
      slot_q   <= '0;
      cnt_q    <= '0;
      idx_q    <= '0;
    end else begin
      sync_q <= sync_i;
      if (halt_i) begin
        active_q <= 1'b0;
      end else if (bit_en_o) begin
        active_q <= !(last_bit && slot_o == IDX_W'(SLOTS));
        if (last_tag) begin
          slot_q <= IDX_W'(1);
          cnt_q  <= CNT_W'(SLOT_W - 1);
        end else if (slot_o == '0) begin
          slot_q <= '0;
          cnt_q  <= cnt_o + 1'b1;
        end else if (last_bit) begin
          slot_q <= slot_o + 1'b1;
          cnt_q  <= CNT_W'(SLOT_W - 1);
          idx_q  <= slot_o;
        end else begin
          slot_q <= slot_o;
          cnt_q  <= cnt_o - 1'b1;
        end
      end
    end
  end

  assign idx_o = idx_q;

  p_idx_range_r4: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (bit_en_o && last_bit) |=> (idx_q >= IDX_W'(1) && idx_q <= IDX_W'(SLOTS)));

  p_halt_stops_r7: assert property (@(negedge clk_i) disable iff (!rst_ni)
    halt_i |=> !active_q);
endmodule

// File: rtl/acl_rx_lane.sv
module acl_rx_lane #(
  parameter int unsigned TAG_W  = 16,
  parameter int unsigned SLOTS  = 12,
  parameter int unsigned SLOT_W = 20,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned CNT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sd_i,
  input  logic              halt_i,
  input  logic              bit_en_i,
  input  logic [IDX_W-1:0]  slot_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              ready_o,
  output logic [SLOTS-1:0]  valid_o,
  output logic [SLOT_W-1:0] data_o,
  output logic              stb_o,
  output logic              wake_o
);
  logic              stage_rdy, ready_q, stb_q, wake_q;
  logic [SLOTS-1:0]  stage_vld, valid_q;
  logic [SLOT_W-2:0] sh_q;
  logic [SLOT_W-1:0] data_q;
  logic              in_tag;

  assign in_tag = (slot_i == '0);

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_rdy <= 1'b0;
      stage_vld <= '0;
      ready_q   <= 1'b0;
      valid_q   <= '0;
      sh_q      <= '0;
      data_q    <= '0;
      stb_q     <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (halt_i) begin
        ready_q <= 1'b0;
        valid_q <= '0;
      end else if (bit_en_i) begin
        if (in_tag) begin
          if (cnt_i == '0) stage_rdy <= sd_i;
          for (int k = 0; k < SLOTS; k++)
            if (cnt_i == CNT_W'(k + 1)) stage_vld[k] <= sd_i;
          if (cnt_i == CNT_W'(TAG_W - 1)) begin
            ready_q <= stage_rdy;
            valid_q <= stage_vld;
          end
        end else begin
          sh_q <= {sh_q[SLOT_W-3:0], sd_i};
          if (cnt_i == '0) begin
            data_q <= {sh_q, sd_i};
            stb_q  <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wake_q <= 1'b0;
    else if (!halt_i) wake_q <= 1'b0;
    else if (sd_i)    wake_q <= 1'b1;
  end

  assign ready_o = ready_q;
  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign stb_o   = stb_q;
  assign wake_o  = wake_q;

  p_stb_single_r4: assert property (@(negedge clk_i) disable iff (!rst_ni)
    stb_q |=> !stb_q);

  p_halt_quiet_r7: assert property (@(negedge clk_i) disable iff (!rst_ni)
    halt_i |=> (!stb_q && !ready_q && valid_q == '0));

  p_wake_cause_r7: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $rose(wake_q) |-> $past(halt_i && sd_i));

  p_wake_drop_r7: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !halt_i |=> !wake_q);
endmodule

// File: rtl/acl_rx_dual.sv
module acl_rx_dual
  import acl_rx_pkg::*;
#(
  parameter int unsigned NUM_IN = NUM_IN_DEF,
  parameter int unsigned SLOTS  = SLOTS_DEF,
  parameter int unsigned SLOT_W = SLOT_W_DEF,
  parameter int unsigned TAG_W  = TAG_W_DEF,
  localparam int unsigned IDX_W = $clog2(SLOTS + 1),
  localparam int unsigned CNT_W = cnt_width(TAG_W, SLOT_W)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sync_i,
  input  logic                     shutoff_i,
  input  logic [NUM_IN-1:0]        sdin_i,
  output logic [NUM_IN-1:0]        ready_o,
  output logic [NUM_IN*SLOTS-1:0]  slot_valid_o,
  output logic [NUM_IN*SLOT_W-1:0] slot_data_o,
  output logic [NUM_IN-1:0]        slot_stb_o,
  output logic [IDX_W-1:0]         slot_idx_o,
  output logic [NUM_IN-1:0]        wake_o
);
  logic             bit_en;
  logic [IDX_W-1:0] cur_slot;
  logic [CNT_W-1:0] cur_cnt;

  acl_rx_framer #(
    .TAG_W(TAG_W), .SLOTS(SLOTS), .SLOT_W(SLOT_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) i_framer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sync_i   (sync_i),
    .halt_i   (shutoff_i),
    .bit_en_o (bit_en),
    .slot_o   (cur_slot),
    .cnt_o    (cur_cnt),
    .idx_o    (slot_idx_o)
  );

  for (genvar g = 0; g < NUM_IN; g++) begin : g_lane
    acl_rx_lane #(
      .TAG_W(TAG_W), .SLOTS(SLOTS), .SLOT_W(SLOT_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) i_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sd_i     (sdin_i[g]),
      .halt_i   (shutoff_i),
      .bit_en_i (bit_en),
      .slot_i   (cur_slot),
      .cnt_i    (cur_cnt),
      .ready_o  (ready_o[g]),
      .valid_o  (slot_valid_o[g*SLOTS +: SLOTS]),
      .data_o   (slot_data_o[g*SLOT_W +: SLOT_W]),
      .stb_o    (slot_stb_o[g]),
      .wake_o   (wake_o[g])
    );
  end

  p_stb_lockstep_r5: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (slot_stb_o == '0) || (slot_stb_o == '1));
endmodule

// File: tb/test_acl_rx_dual.sv
module test_acl_rx_dual;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sync = 1'b0, shutoff = 1'b0;
  logic [1:0]  sdin = '0;
  logic [1:0]  ready, stb, wake;
  logic [23:0] valid;
  logic [39:0] sdata;
  logic [3:0]  idx;

  int errors = 0, checks = 0;
  logic [23:0] q0[$], q1[$];

  always #(CLK_P/2) clk = ~clk;

  acl_rx_dual i_acl_rx_dual (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .shutoff_i(shutoff),
    .sdin_i(sdin), .ready_o(ready), .slot_valid_o(valid), .slot_data_o(sdata),
    .slot_stb_o(stb), .slot_idx_o(idx), .wake_o(wake)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] gen(input int seed, input int k);
    if (seed < 0) return '0;
    return 20'((seed * 40503 + k * 7919) ^ (k << 13) ^ (seed << 7));
  endfunction

  // scoreboard monitor: pop on every strobe (R4, R5, R8)
  always @(posedge clk) begin
    if (rst_n) begin
      if (stb[0]) begin
        if (q0.size() == 0) check(1'b0, "R8 lane0 unexpected strobe", {idx, sdata[19:0]}, 0);
        else begin
          logic [23:0] e;
          e = q0.pop_front();
          check({idx, sdata[19:0]} == e, "R4 lane0 slot idx/data", {idx, sdata[19:0]}, e);
        end
      end
      if (stb[1]) begin
        if (q1.size() == 0) check(1'b0, "R8 lane1 unexpected strobe", {idx, sdata[39:20]}, 0);
        else begin
          logic [23:0] e;
          e = q1.pop_front();
          check({idx, sdata[39:20]} == e, "R5 lane1 slot idx/data", {idx, sdata[39:20]}, e);
        end
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      sync = 1'b0; sdin = '0;
    end
  endtask

  // driver: builds frames, pushes expected slots, drives bits on rising edges (R1)
  task automatic run_frame(input int s0, input int s1, input logic r0, input logic r1,
                           input logic [11:0] v0, input logic [11:0] v1, input int nbits);
    logic [255:0] f0, f1;
    f0 = '0; f1 = '0;
    f0[0] = r0; f1[0] = r1;
    for (int k = 1; k <= 12; k++) begin
      f0[k] = v0[k-1]; f1[k] = v1[k-1];
      for (int b = 0; b < 20; b++) begin
        f0[16 + 20*(k-1) + (19-b)] = gen(s0, k)[b];
        f1[16 + 20*(k-1) + (19-b)] = gen(s1, k)[b];
      end
      if (16 + 20*k <= nbits) begin
        q0.push_back({4'(k), gen(s0, k)});
        q1.push_back({4'(k), gen(s1, k)});
      end
    end
    for (int p = 0; p < nbits; p++) begin
      @(posedge clk); #1;
      sync = (p < 16);
      sdin = {f1[p], f0[p]};
    end
  endtask

  task automatic check_tag(input string req, input logic r0, input logic r1,
                           input logic [11:0] v0, input logic [11:0] v1);
    check(ready == {r1, r0}, req, 64'(ready), 64'({r1, r0}));
    check(valid == {v1, v0}, req, 64'(valid), 64'({v1, v0}));
  endtask

  initial begin
    #(CLK_P * 200000);
    check(1'b0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    // R9: reset state
    check(ready == '0 && wake == '0, "R9 reset ready/wake", {ready, wake}, 0);
    check(valid == '0 && stb == '0, "R9 reset valid/stb", {valid, stb}, 0);
    check(sdata == '0 && idx == '0, "R9 reset data/idx", {sdata, idx}, 0);
    #1 rst_n = 1'b1;
    idle(5);

    // R3/R5: both lines decoded independently
    run_frame(3, 11, 1'b1, 1'b1, 12'hA5C, 12'h3F1, 256);
    idle(3);
    check_tag("R3 tag decode frame A", 1'b1, 1'b1, 12'hA5C, 12'h3F1);
    check(q0.size() == 0 && q1.size() == 0, "R4 all slots of frame A seen", q0.size() + q1.size(), 0);

    // R6: line 1 tied low
    run_frame(7, -1, 1'b1, 1'b0, 12'hFFF, 12'h000, 256);
    idle(2);
    check_tag("R6 line1 low not ready/invalid", 1'b1, 1'b0, 12'hFFF, 12'h000);
    check(sdata[39:20] == '0, "R6 line1 data zero", sdata[39:20], 0);

    // R2: abandoned frame then immediate resync
    run_frame(21, 5, 1'b0, 1'b1, 12'h0F0, 12'h801, 100);
    check_tag("R3 partial frame tag committed", 1'b0, 1'b1, 12'h0F0, 12'h801);
    run_frame(9, 14, 1'b1, 1'b0, 12'h123, 12'hE6D, 256);
    idle(1);
    check_tag("R2 resync frame tag", 1'b1, 1'b0, 12'h123, 12'hE6D);
    check(q0.size() == 0 && q1.size() == 0, "R2 resync slots all seen", q0.size() + q1.size(), 0);

    // R8: nothing after frame end (monitor flags any strobe)
    idle(40);
    check(stb == '0, "R8 idle no strobe", stb, 0);

    // R7: shutoff, wake on line 0 only, then both
    @(posedge clk); #1 shutoff = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1;
      sync = (i % 20) < 4;
      sdin = {1'b0, (i >= 10)};
    end
    @(posedge clk);
    check(wake == 2'b01, "R7 wake line0 only", wake, 2'b01);
    check(ready == '0 && valid == '0, "R7 shutoff clears tag", {ready, valid}, 0);
    #1 sdin = 2'b10;
    @(posedge clk);
    check(wake == 2'b11, "R7 wake sticky both lines", wake, 2'b11);
    #1 shutoff = 1'b0; sdin = '0; sync = 1'b0;
    @(posedge clk);
    check(wake == 2'b00, "R7 wake cleared", wake, 0);
    idle(4);

    // R1: normal operation after shutoff
    run_frame(33, 2, 1'b1, 1'b1, 12'h555, 12'hAAA, 256);
    idle(3);
    check_tag("R1 frame after shutoff tag", 1'b1, 1'b1, 12'h555, 12'hAAA);
    check(q0.size() == 0 && q1.size() == 0, "R1 final slots all seen", q0.size() + q1.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule